// File: doc/BRIEF.md
# Planar Indexed Pixel Fetch Unit

This block turns one pixel request into a palette-entry address. A request names a 16x16 image (or a 16x32 double-height pair), a pixel column and row inside it, horizontal and vertical mirroring, a transparency enable, a sprite/tile half selector and a palette number. The block locates the pixel row in image memory, reads the three bitplanes of that row as three 16-bit byte pairs over a synchronous read port, and assembles the pixel's 3-bit colour index.

The result is the byte address of the matching two-byte colour entry in palette memory. It comes with a flag that marks the pixel as not drawn. A renderer issues one request per pixel and gets one result per request. It may issue the next request in the cycle the previous result appears.

Top module: `pix_fetch`

## Requirements
- R1: A request is taken when `start_i` is high in a cycle where `busy_o` is low. From the next cycle, `busy_o` stays high until the result appears. A `start_i` seen while `busy_o` is high is ignored and produces no result.
- R2: A taken request issues exactly three reads on consecutive cycles at addresses B, B+2 and B+4, where B is the row base. `mem_rdata_i` carries the word read one cycle after each `mem_req_o`. If the request is taken at clock edge k, `valid_o` is high for exactly one cycle, between edges k+4 and k+5.
- R3: The row base is B = (tile_sel ? 0x3000 : 0) + image*96 + row*6. The half selected by `tile_sel_i` holds 128 images. All reads fall below 0x6000.
- R4: Each read word is {byte at A+1, byte at A}. Pixel column c (0 = leftmost) uses word bit {c[3], ~c[2:0]}, so column 0 is bit 7. The read at B gives the index MSB, the read at B+2 the middle bit and the read at B+4 the LSB.
- R5: With `hflip_i` set, column 15-x is used instead of x.
- R6: In single-height mode the row is y[3:0] (y[4] has no effect), or 15-y[3:0] with `vflip_i` set.
- R7: In double-height mode the image index LSB is ignored. Rows 16..31 come from image {idx[6:1],1}. With `vflip_i`, row 31-y is used across all 32 rows, which also swaps the two images.
- R8: `pal_addr_o` = 0x6000 + (tile_sel ? 0x100 : 0) + palette*16 + index*2.
- R9: `transp_o` is high exactly when `transp_en_i` was set and the colour index is 0. With `transp_en_i` clear, index 0 reports a normal palette address and `transp_o` low.
- R10: `pal_addr_o` and `transp_o` change only together with a `valid_o` pulse and hold their values otherwise. A request taken in the cycle `valid_o` is high is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| img_idx_i | input | 7 | Image index within the selected half |
| x_i | input | 4 | Pixel column |
| y_i | input | 5 | Pixel row (bit 4 used only in double-height mode) |
| hflip_i | input | 1 | Mirror columns |
| vflip_i | input | 1 | Mirror rows |
| transp_en_i | input | 1 | Index 0 means not drawn |
| dbl_i | input | 1 | Double-height 16x32 mode |
| tile_sel_i | input | 1 | 0 = sprite half, 1 = tile half |
| pal_i | input | 4 | Palette number |
| busy_o | output | 1 | Request in progress |
| mem_req_o | output | 1 | Image memory read strobe |
| mem_addr_o | output | 15 | Image memory byte address |
| mem_rdata_i | input | 16 | Read word, one cycle after the strobe |
| valid_o | output | 1 | One-cycle result strobe |
| pal_addr_o | output | 15 | Palette colour entry address |
| transp_o | output | 1 | Pixel not drawn |

## Verification
Two events can fall in the same cycle: the result pulse of one request and the acceptance of the next. The driver provokes this by issuing each request at the first falling edge where `busy_o` is low, which is the cycle `valid_o` is high. The scoreboard then checks that the first result carries the earlier request's values at its expected cycle, and that the second request's three reads and its result follow on schedule. A start asserted mid-fetch with different operands is also checked: it must leave both the result and the read sequence untouched.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned ROW_BYTES     = 6;
  localparam int unsigned IMG_BYTES     = 96;
  localparam int unsigned TILE_IMG_BASE = 'h3000;
  localparam int unsigned PAL_BASE      = 'h6000;
  localparam int unsigned PAL_TILE_OFS  = 'h100;
  localparam int unsigned PAL_BYTES     = 16;
  localparam int unsigned ENTRY_BYTES   = 2;
  localparam int unsigned N_PLANES      = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_FIN
  } pf_state_e;
endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  output logic       busy_o,
  output logic       req_o,
  output logic [1:0] phase_o,
  output logic [1:0] cap_o,
  output logic       last_o
);
  pf_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_i) st_d = ST_RD0;
      ST_RD0:  st_d = ST_RD1;
      ST_RD1:  st_d = ST_RD2;
      ST_RD2:  st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o = (st_q != ST_IDLE);
  assign req_o  = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_RD2);
  always_comb begin
    unique case (st_q)
      ST_RD1:  phase_o = 2'd1;
      ST_RD2:  phase_o = 2'd2;
      default: phase_o = 2'd0;
    endcase
  end
  // read data of phase k is on the bus in the following state
  assign cap_o[0] = (st_q == ST_RD1);
  assign cap_o[1] = (st_q == ST_RD2);
  assign last_o   = (st_q == ST_FIN);
endmodule

// File: rtl/pf_row_addr.sv
module pf_row_addr
  import pf_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned COL_W  = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [COL_W:0]    y_i,
  input  logic              vflip_i,
  input  logic              dbl_i,
  input  logic              tile_sel_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [COL_W:0]   y_m;
  logic [IDX_W-1:0] idx_eff;
  logic [COL_W-1:0] row;

  // ~y mirrors over 32 rows; low bits alone mirror over 16
  assign y_m     = vflip_i ? ~y_i : y_i;
  assign idx_eff = dbl_i ? {idx_i[IDX_W-1:1], y_m[COL_W]} : idx_i;
  assign row     = y_m[COL_W-1:0];

  assign base_o = (tile_sel_i ? ADDR_W'(TILE_IMG_BASE) : '0)
                + ADDR_W'(idx_eff) * ADDR_W'(IMG_BYTES)
                + ADDR_W'(row) * ADDR_W'(ROW_BYTES);
endmodule

// File: rtl/pf_plane_bit.sv
module pf_plane_bit #(
  parameter int unsigned COL_W = 4
) (
  input  logic [(1<<COL_W)-1:0] word_i,
  input  logic [COL_W-1:0]      col_i,
  output logic                  bit_o
);
  // low byte first, leftmost pixel at each byte's MSB
  logic [COL_W-1:0] sel;
  assign sel   = {col_i[COL_W-1], ~col_i[COL_W-2:0]};
  assign bit_o = word_i[sel];
endmodule

// File: rtl/pix_fetch.sv
module pix_fetch
  import pf_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAL_W  = 4,
  parameter int unsigned SIDE   = 16,
  localparam int unsigned COL_W  = $clog2(SIDE),
  localparam int unsigned WORD_W = SIDE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  img_idx_i,
  input  logic [COL_W-1:0]  x_i,
  input  logic [COL_W:0]    y_i,
  input  logic              hflip_i,
  input  logic              vflip_i,
  input  logic              transp_en_i,
  input  logic              dbl_i,
  input  logic              tile_sel_i,
  input  logic [PAL_W-1:0]  pal_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] pal_addr_o,
  output logic              transp_o
);
  localparam int unsigned CI_W = N_PLANES;

  logic              accept, last;
  logic [1:0]        phase, cap;
  logic [IDX_W-1:0]  idx_q;
  logic [COL_W-1:0]  x_q, col;
  logic [COL_W:0]    y_q;
  logic              hflip_q, vflip_q, tsp_q, dbl_q, tile_q;
  logic [PAL_W-1:0]  pal_q;
  logic [ADDR_W-1:0] base;
  logic              pbit;
  logic [N_PLANES-2:0] plane_q;
  logic [CI_W-1:0]   ci;

  assign accept = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; x_q <= '0; y_q <= '0; pal_q <= '0;
      hflip_q <= 1'b0; vflip_q <= 1'b0; tsp_q <= 1'b0;
      dbl_q <= 1'b0; tile_q <= 1'b0;
    end else if (accept) begin
      idx_q <= img_idx_i; x_q <= x_i; y_q <= y_i; pal_q <= pal_i;
      hflip_q <= hflip_i; vflip_q <= vflip_i; tsp_q <= transp_en_i;
      dbl_q <= dbl_i; tile_q <= tile_sel_i;
    end
  end

  pf_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .busy_o  (busy_o),
    .req_o   (mem_req_o),
    .phase_o (phase),
    .cap_o   (cap),
    .last_o  (last)
  );

  pf_row_addr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .COL_W(COL_W)) u_row (
    .idx_i     (idx_q),
    .y_i       (y_q),
    .vflip_i   (vflip_q),
    .dbl_i     (dbl_q),
    .tile_sel_i(tile_q),
    .base_o    (base)
  );

  assign mem_addr_o = base + ADDR_W'({phase, 1'b0});

  assign col = hflip_q ? ~x_q : x_q;

  pf_plane_bit #(.COL_W(COL_W)) u_bit (
    .word_i(mem_rdata_i),
    .col_i (col),
    .bit_o (pbit)
  );

  for (genvar k = 0; k < N_PLANES - 1; k++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     plane_q[k] <= 1'b0;
      else if (cap[k]) plane_q[k] <= pbit;
    end
  end

  // first plane is the MSB; last plane taken live from the bus
  always_comb begin
    ci[0] = pbit;
    for (int k = 0; k < N_PLANES - 1; k++) ci[CI_W-1-k] = plane_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      pal_addr_o <= '0;
      transp_o   <= 1'b0;
    end else begin
      valid_o <= last;
      if (last) begin
        pal_addr_o <= ADDR_W'(PAL_BASE)
                    + (tile_q ? ADDR_W'(PAL_TILE_OFS) : '0)
                    + ADDR_W'(pal_q) * ADDR_W'(PAL_BYTES)
                    + ADDR_W'(ci) * ADDR_W'(ENTRY_BYTES);
        transp_o   <= tsp_q && (ci == '0);
      end
    end
  end
endmodule

// File: rtl/pf_fetch_chk.sv
module pf_fetch_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              valid_o,
  input logic [ADDR_W-1:0] pal_addr_o,
  input logic              transp_o
);
  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_req_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && !busy_o, 5) |-> valid_o);

  assert_one_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_img_region_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o < ADDR_W'('h6000)));

  assert_pal_region_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pal_addr_o >= ADDR_W'('h6000) && pal_addr_o < ADDR_W'('h6200) && !pal_addr_o[0]));

  assert_transp_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && transp_o) |-> (pal_addr_o[3:1] == 3'd0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(pal_addr_o) && $stable(transp_o)));
endmodule

bind pix_fetch pf_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .valid_o   (valid_o),
  .pal_addr_o(pal_addr_o),
  .transp_o  (transp_o)
);

// File: tb/pix_fetch_tb_top.sv
`timescale 1ns/1ps
module pix_fetch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [6:0]  idx = '0;
  logic [3:0]  x = '0;
  logic [4:0]  y = '0;
  logic        hf = 1'b0, vf = 1'b0, te = 1'b0, db = 1'b0, ts = 1'b0;
  logic [3:0]  pal = '0;
  logic        busy, mreq, valid, transp;
  logic [14:0] maddr, paddr;
  logic [15:0] rdata = '0;

  pix_fetch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .img_idx_i(idx),
    .x_i(x), .y_i(y), .hflip_i(hf), .vflip_i(vf), .transp_en_i(te),
    .dbl_i(db), .tile_sel_i(ts), .pal_i(pal), .busy_o(busy),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_rdata_i(rdata),
    .valid_o(valid), .pal_addr_o(paddr), .transp_o(transp)
  );

  function automatic logic [7:0] hb(int a);
    int t;
    t = a * 37 + (a >>> 6) * 11 + 'h5a;
    return t[7:0] ^ 8'(a >>> 9);
  endfunction

  always_ff @(posedge clk) if (mreq) rdata <= {hb(int'(maddr) + 1), hb(int'(maddr))};

  typedef struct {
    int    pa;
    bit    tr;
    int    cyc;
    string rq;
  } exp_t;

  exp_t exp_q[$];
  int   addr_q[$];
  int   total = 0, bad = 0, cyc = 0;
  int   last_pa = 0;
  bit   last_tr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  // reference computed straight from the requirement text
  task automatic model(input int i, xi, yi, input bit h, v, t, d, s, input int p,
                       output int base, output int pa, output bit tr);
    int yy, eff, row, c, ci, w, b;
    if (d) yy = v ? 31 - yi : yi;
    else   yy = v ? 15 - (yi % 16) : (yi % 16);
    eff  = d ? ((i / 2) * 2 + (yy >= 16 ? 1 : 0)) : i;
    row  = yy % 16;
    base = (s ? 'h3000 : 0) + eff * 96 + row * 6;
    c    = h ? 15 - xi : xi;
    ci   = 0;
    for (int k = 0; k < 3; k++) begin
      w  = hb(base + 2 * k) + 256 * hb(base + 2 * k + 1);
      b  = (c < 8) ? ((w >> (7 - c)) & 1) : ((w >> (23 - c)) & 1);
      ci = ci * 2 + b;
    end
    pa = 'h6000 + (s ? 'h100 : 0) + p * 16 + ci * 2;
    tr = t && (ci == 0);
  endtask

  task automatic go(input int i, xi, yi, input bit h, v, t, d, s, input int p, input string rq);
    int base, pa;
    bit tr;
    exp_t e;
    while (busy) @(negedge clk);
    idx = 7'(i); x = 4'(xi); y = 5'(yi); hf = h; vf = v; te = t; db = d; ts = s; pal = 4'(p);
    start = 1'b1;
    model(i, xi, yi, h, v, t, d, s, p, base, pa, tr);
    e.pa = pa; e.tr = tr; e.cyc = cyc + 5; e.rq = rq;
    exp_q.push_back(e);
    for (int k = 0; k < 3; k++) addr_q.push_back(base + 2 * k);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (mreq) begin
      if (addr_q.size() == 0) chk(0, "R1", "unexpected read", int'(maddr), -1);
      else begin
        int ea;
        ea = addr_q.pop_front();
        chk(int'(maddr) == ea, "R2_R3", "read address", int'(maddr), ea);
      end
    end
    if (valid) begin
      if (exp_q.size() == 0) chk(0, "R1", "unexpected result", int'(paddr), -1);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.cyc, "R2", "result cycle", cyc, e.cyc);
        chk(int'(paddr) == e.pa, e.rq, "palette address", int'(paddr), e.pa);
        chk(transp == e.tr, e.rq, "transparent flag", int'(transp), int'(e.tr));
        last_pa = e.pa; last_tr = e.tr;
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(0, "R2", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mreq && !valid, "R1", "reset outputs", {busy, mreq, valid}, 0);
    chk(paddr == 15'd0, "R10", "reset result", int'(paddr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4 plain fetches, both halves, extreme indices and rows
    go(0,   0,  0, 0, 0, 0, 0, 0, 0,  "R3_R4");
    go(2,   7,  3, 0, 0, 0, 0, 0, 5,  "R3_R4");
    go(127, 15, 15, 0, 0, 0, 0, 1, 15, "R3_R8");
    go(127, 8,  15, 0, 0, 0, 0, 0, 3,  "R4_R8");
    // R5 mirrored columns
    go(9,   0,  4, 1, 0, 0, 0, 0, 1,  "R5");
    go(9,   15, 4, 1, 0, 0, 0, 1, 2,  "R5");
    // R6 vertical mirror, and y bit 4 with no effect in single height
    go(20,  3,  2, 0, 1, 0, 0, 0, 7,  "R6");
    go(20,  3, 18, 0, 0, 0, 0, 0, 7,  "R6");
    // R7 double height: odd index, lower half, mirrored across 32 rows
    go(5,   6,  3, 0, 0, 0, 1, 0, 4,  "R7");
    go(5,   6, 20, 0, 0, 0, 1, 1, 4,  "R7");
    go(5,   6,  3, 0, 1, 0, 1, 0, 4,  "R7");
    go(126, 12, 31, 1, 1, 0, 1, 1, 9, "R7");

    // R1 start during busy is ignored
    go(40,  2,  6, 0, 0, 1, 0, 0, 6,  "R1");
    @(negedge clk);
    idx = 7'd99; ts = 1'b1; pal = 4'd12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // R8/R9/R10 randomised, issued back to back
    for (int n = 0; n < 150; n++) begin
      int r;
      r = $urandom;
      go($urandom % 128, $urandom % 16, $urandom % 32, r[0], r[1], r[2], r[3], r[4],
         $urandom % 16, r[2] ? "R9_R10" : "R8_R10");
    end

    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(int'(paddr) == last_pa, "R10", "held address", int'(paddr), last_pa);
    chk(transp == last_tr, "R10", "held flag", int'(transp), int'(last_tr));
    chk(addr_q.size() == 0, "R2", "reads outstanding", addr_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule